// File: doc/BRIEF.md
# Pipelined Half-Word Selecting Multiplier

This block multiplies two 16-bit operands into a 32-bit product. Each operand is cut from a 32-bit source word, and a per-operand flag picks the upper half or the lower half of that word. A two-bit mode input sets how the two halves are read. They can both be signed, the first signed and the second unsigned, or both unsigned. A fourth mode treats both halves as signed Q15 fractions.

The block is a fixed two-stage pipeline. An operation presented with the issue strobe on one clock edge produces its product and a valid flag two edges later. A new operation can be issued on every edge.

In fractional mode the signed product is doubled. The one case that cannot be represented is the most negative value times itself. That case is clamped to the largest positive 32-bit value, and a saturation event is flagged alongside the result. A synchronous reset empties the pipeline.

Top module: `hw_mult`

## Requirements
- R1: `hi_a` = 1 takes operand A from `src_a[31:16]`; `hi_a` = 0 takes it from `src_a[15:0]`.
- R2: `hi_b` selects operand B from `src_b` in the same way as R1, independently of `hi_a`.
- R3: Mode 2'b00 gives the 32-bit two's-complement product of signed A and signed B.
- R4: Mode 2'b01 gives the product of signed A and unsigned B, truncated to its low 32 bits.
- R5: Mode 2'b10 gives the product of unsigned A and unsigned B.
- R6: Mode 2'b11 (fractional) gives the signed product shifted left by one bit, keeping the low 32 bits.
- R7: In mode 2'b11, when both selected halves are 16'h8000, the product is 32'h7FFFFFFF and `sat` is 1 in the same cycle as `valid`.
- R8: `sat` is 0 for every result of modes 2'b00, 2'b01 and 2'b10, and for every other fractional result. This includes 16'hFFFF times 16'hFFFF unsigned.
- R9: `valid` is 1 exactly two rising edges after an edge that sampled `issue` = 1, and 0 otherwise. `prod` and `sat` belong to that operation.
- R10: Operations issued on consecutive edges each produce their own correct result on consecutive cycles.
- R11: A synchronous reset drives `valid` and `sat` to 0 and drops any operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Starts an operation on this edge |
| mode | input | 2 | 00 signed, 01 signed x unsigned, 10 unsigned, 11 fractional |
| hi_a | input | 1 | Upper-half select for operand A |
| hi_b | input | 1 | Upper-half select for operand B |
| src_a | input | 32 | Source word for operand A |
| src_b | input | 32 | Source word for operand B |
| prod | output | 32 | Product |
| valid | output | 1 | Product valid |
| sat | output | 1 | Fractional saturation event |

## Verification
The source words are given different values in their two halves, and all four select combinations are tried. A swapped or shared select therefore shows up as a wrong product. Halves of 16'hFFFF and 16'h8000 are run through every mode. Because these values read differently as signed and unsigned, they separate the four sign treatments, and they also expose the single fractional overflow.

A long burst of back-to-back random operations is compared against a behavioural queue model. Sparse issues are used to pin the latency. A reset is applied while operations are in flight and must drop them.

// File: rtl/hw_mult.sv
module hw_mult #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic [1:0]      mode,
  input  logic            hi_a,
  input  logic            hi_b,
  input  logic [2*W-1:0]  src_a,
  input  logic [2*W-1:0]  src_b,
  output logic [2*W-1:0]  prod,
  output logic            valid,
  output logic            sat
);
  localparam int SW = 2 * W;
  localparam logic [1:0] M_SS = 2'b00, M_SU = 2'b01, M_UU = 2'b10, M_FR = 2'b11;
  localparam logic [W:0] MOST_NEG = {2'b11, {(W-1){1'b0}}};

  logic [W-1:0] a_half, b_half;
  logic         a_sx, b_sx;

  assign a_half = hi_a ? src_a[SW-1:W] : src_a[W-1:0];
  assign b_half = hi_b ? src_b[SW-1:W] : src_b[W-1:0];
  assign a_sx   = (mode != M_UU);
  assign b_sx   = (mode == M_SS) || (mode == M_FR);

  logic signed [W:0] a1, b1;
  logic              frac1, v1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= issue;
    a1    <= {a_sx & a_half[W-1], a_half};
    b1    <= {b_sx & b_half[W-1], b_half};
    frac1 <= (mode == M_FR);
  end

  logic signed [SW-1:0] full;
  logic                 ovf;

  assign full = SW'(a1) * SW'(b1);
  assign ovf  = frac1 && (a1 == MOST_NEG) && (b1 == MOST_NEG);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      sat   <= 1'b0;
    end else begin
      valid <= v1;
      sat   <= v1 & ovf;
    end
    if (ovf)        prod <= {1'b0, {(SW-1){1'b1}}};
    else if (frac1) prod <= {full[SW-2:0], 1'b0};
    else            prod <= full;
  end

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (valid == $past(issue, 2)));

  // R7
  frac_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && mode == M_FR && a_half == {1'b1, {(W-1){1'b0}}} && b_half == {1'b1, {(W-1){1'b0}}})
    |-> ##2 (valid && sat && prod == {1'b0, {(SW-1){1'b1}}}));

  // R8
  int_nosat_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && mode != M_FR) |-> ##2 !sat);

  // R1
  upper_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && mode == M_UU && hi_a && hi_b) |-> ##2
    (prod == {{W{1'b0}}, $past(src_a[SW-1:W], 2)} * {{W{1'b0}}, $past(src_b[SW-1:W], 2)}));
endmodule

// File: tb/hw_mult_tb.sv
module hw_mult_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue = 1'b0;
  logic [1:0] mode = 2'b00;
  logic hi_a = 1'b0, hi_b = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [31:0] prod;
  logic valid, sat;
  string cur_tag = "R11";

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  hw_mult u_dut (
    .clk(clk), .rst(rst), .issue(issue), .mode(mode), .hi_a(hi_a), .hi_b(hi_b),
    .src_a(src_a), .src_b(src_b), .prod(prod), .valid(valid), .sat(sat)
  );

  function automatic logic [32:0] ref_mul(logic [1:0] m, logic ha, logic hb,
                                          logic [31:0] a, logic [31:0] b);
    logic [15:0] ah, bh;
    longint x, y, p;
    ah = ha ? a[31:16] : a[15:0];
    bh = hb ? b[31:16] : b[15:0];
    x = (m == 2'b10) ? longint'(ah) : longint'($signed(ah));
    y = (m == 2'b00 || m == 2'b11) ? longint'($signed(bh)) : longint'(bh);
    p = x * y;
    if (m == 2'b11) begin
      if (ah == 16'h8000 && bh == 16'h8000) return {1'b1, 32'h7FFFFFFF};
      p = p * 2;
    end
    return {1'b0, p[31:0]};
  endfunction

  logic m1v = 1'b0, m2v = 1'b0;
  logic [32:0] m1r, m2r;
  string m1t, m2t;

  always @(posedge clk) begin
    if (rst) begin
      m1v <= 1'b0;
      m2v <= 1'b0;
    end else begin
      m1v <= issue;
      m2v <= m1v;
    end
    m1r <= ref_mul(mode, hi_a, hi_b, src_a, src_b);
    m1t <= cur_tag;
    m2r <= m1r;
    m2t <= m1t;
  end

  task automatic check(string tag, logic ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check(rst ? "R11" : "R9", valid == m2v, 64'(valid), 64'(m2v));
    if (valid && m2v) begin
      check(m2t, prod == m2r[31:0], 64'(prod), 64'(m2r[31:0]));
      check(m2r[32] ? "R7" : "R8", sat == m2r[32], 64'(sat), 64'(m2r[32]));
    end else begin
      check("R11", sat == 1'b0, 64'(sat), 64'd0);
    end
  end

  task automatic op(string tag, logic [1:0] m, logic ha, logic hb, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    issue = 1'b1; mode = m; hi_a = ha; hi_b = hb; src_a = a; src_b = b; cur_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issue = 1'b0; cur_tag = "R9";
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1, R2: all four select combinations with distinct halves
    op("R1", 2'b00, 1'b0, 1'b0, 32'h0005_0003, 32'h0007_0002);
    op("R1", 2'b00, 1'b1, 1'b0, 32'h0005_0003, 32'h0007_0002);
    op("R2", 2'b00, 1'b0, 1'b1, 32'h0005_0003, 32'h0007_0002);
    op("R2", 2'b00, 1'b1, 1'b1, 32'h0005_0003, 32'h0007_0002);
    idle(3);
    // R3, R4, R5: sign treatments separated by 0xFFFF and 0x8000
    op("R3", 2'b00, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF);
    op("R4", 2'b01, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF);
    op("R5", 2'b10, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF);
    op("R3", 2'b00, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_8000);
    op("R4", 2'b01, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_8000);
    op("R5", 2'b10, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000);
    idle(1);
    // R6, R7: fractional results and the overflow clamp
    op("R6", 2'b11, 1'b0, 1'b0, 32'h0000_4000, 32'h0000_4000);
    op("R6", 2'b11, 1'b0, 1'b1, 32'h0000_8000, 32'h7FFF_0000);
    op("R7", 2'b11, 1'b1, 1'b0, 32'h8000_1234, 32'h5678_8000);
    op("R6", 2'b11, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_8000);
    op("R7", 2'b11, 1'b0, 1'b1, 32'h0000_8000, 32'h8000_0000);
    idle(2);
    // R10: back-to-back random burst
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [1:0] rm;
      ra = $urandom; rb = $urandom; rm = 2'($urandom);
      if (i % 13 == 0) begin ra[15:0] = 16'h8000; rb[31:16] = 16'h8000; end
      op("R10", rm, 1'($urandom), 1'($urandom), ra, rb);
    end
    idle(3);
    // R9: sparse issues
    for (int i = 0; i < 20; i++) begin
      op("R9", 2'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);
      idle(i % 4);
    end
    idle(3);
    // R11: reset with operations in flight
    op("R11", 2'b11, 1'b0, 1'b0, 32'h8000, 32'h8000);
    op("R11", 2'b00, 1'b0, 1'b0, 32'h3, 32'h4);
    @(negedge clk);
    issue = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule